// File: doc/BRIEF.md
# Byte SEC-DED Hamming Codec with Parity Mode

This block sits between a byte-wide datapath and a storage array. On the write side it turns an 8-bit value into a 13-bit code word. The code word is a 12-bit Hamming word, with the check bits at the power-of-two positions, plus one bit of overall parity. On the read side it takes a 13-bit code word back from storage and recomputes the check bits. The XOR of the stored and recomputed check bits is the syndrome, and a non-zero syndrome names the position of a flipped bit. The overall parity bit tells a single error apart from a double error. The block then returns the repaired byte, or it raises a flag saying the word cannot be trusted.

A run-time select replaces the Hamming code with plain parity, one bit per byte. The polarity of that parity, even or odd, is also chosen at run time. Both paths are registered. A write strobe loads the write-side code register, and a read strobe loads the read-side result registers. A register holds its value while its strobe is low. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ecc_byte_codec`

## Requirements
- R1: In Hamming mode, code bit index i holds codeword position i+1. Check bits C1, C2, C4 and C8 sit at indices 0, 1, 3 and 7. Data bits d[0..3] sit at indices 2, 4, 5 and 6, and d[4..7] at indices 8 to 11. The check bits are C1=d0^d1^d3^d4^d6, C2=d0^d2^d3^d5^d6, C4=d1^d2^d3^d7 and C8=d4^d5^d6^d7. Index 12 makes the XOR of all 13 bits zero. For example, 0x39 encodes to 0x134F.
- R2: `wr_code` takes the new code word at the first rising clock edge where `wr_en` is high. It holds its value while `wr_en` is low.
- R3: In Hamming mode, an error-free word returns its data byte with both flags low.
- R4: When exactly one data position is flipped, the original byte is returned and `rd_corrected` is high. For example, the word 0x136F returns 0x39.
- R5: When exactly one check bit or the overall parity bit (index 0, 1, 3, 7 or 12) is flipped, the original byte is returned and `rd_corrected` is high.
- R6: When any two bits are flipped, `rd_uncorrectable` goes high and `rd_corrected` stays low. `rd_data` then carries the data bits exactly as received, with no repair.
- R7: A syndrome of 13, 14 or 15 (for example, flips at indices {0,3,7}, {1,3,7} or {2,3,7}) sets `rd_uncorrectable` and returns the received data bits unaltered.
- R8: In parity mode, `wr_code[7:0]` is the data and `wr_code[8]` is the XOR of the data bits, inverted when `parity_odd` is 1. `wr_code[12:9]` is zero.
- R9: In parity mode, `rd_data` is `rd_code[7:0]` and `rd_corrected` is low. `rd_uncorrectable` is high exactly when bits [8:0] fail the selected parity.
- R10: The read outputs change only at an edge where `rd_en` is high. They hold while `rd_en` is low.
- R11: While reset is asserted, all outputs are zero.
- R12: `rd_corrected` and `rd_uncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parity_mode | input | 1 | 1 selects per-byte parity, 0 selects Hamming SEC-DED |
| parity_odd | input | 1 | 1 selects odd parity in parity mode |
| wr_en | input | 1 | Loads the write-side code register |
| wr_data | input | 8 | Byte to encode |
| wr_code | output | 13 | Registered code word |
| rd_en | input | 1 | Loads the read-side result registers |
| rd_code | input | 13 | Code word read back from storage |
| rd_data | output | 8 | Registered corrected or raw data |
| rd_corrected | output | 1 | A single error was found and handled |
| rd_uncorrectable | output | 1 | The error cannot be corrected |

## Verification
The bench encodes all 256 bytes and decodes each one clean, with every one of the 13 single flips, and with every one of the 78 double flips. This shows whether a swapped data position or a wrong check equation breaks the round trip. It also shows whether a double error gets "repaired" into a wrong byte rather than being flagged. Flips at the check-bit positions and at the overall parity bit are singled out: a design that indexes data by syndrome without screening those positions would corrupt a data bit there. Triple flips that produce syndromes 13 to 15 test the out-of-range guard, whose absence would show as a false correction. Parity mode is swept in both polarities with each of nine single flips, and hold behaviour is tested with the strobes low.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;

  // Smallest check-bit count c with 2^c >= data + c + 1.
  function automatic int calc_chk_w(input int dw);
    int c;
    c = 1;
    while ((1 << c) < dw + c + 1) c = c + 1;
    return c;
  endfunction

  typedef struct packed {
    logic corrected;
    logic fatal;
  } rd_flags_t;

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_q = stage[1];
endmodule

// File: rtl/ecc_hamming_enc.sv
module ecc_hamming_enc
  import ecc_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  localparam int CHK_W  = calc_chk_w(DATA_W),
  localparam int BODY_W = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [BODY_W:0]   code_o
);
  logic [BODY_W-1:0] spread;
  logic [BODY_W-1:0] body;
  logic [CHK_W-1:0]  chk;

  // Position p (1-based) lives at index p-1; powers of two carry check bits.
  for (genvar p = 1; p <= BODY_W; p++) begin : g_pos
    if ((p & (p - 1)) == 0) begin : g_chk
      assign spread[p-1] = 1'b0;
      assign body[p-1]   = chk[$clog2(p)];
    end else begin : g_dat
      assign spread[p-1] = data_i[p-1-$clog2(p+1)];
      assign body[p-1]   = data_i[p-1-$clog2(p+1)];
    end
  end

  always_comb begin
    for (int j = 0; j < CHK_W; j++) begin
      chk[j] = 1'b0;
      for (int p = 1; p <= BODY_W; p++) begin
        if (((p >> j) & 1) == 1) chk[j] = chk[j] ^ spread[p-1];
      end
    end
  end

  if (SECDED) begin : g_ovr
    assign code_o = {^body, body};
  end else begin : g_noovr
    assign code_o = {1'b0, body};
  end
endmodule

// File: rtl/ecc_hamming_syn.sv
module ecc_hamming_syn
  import ecc_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  localparam int CHK_W  = calc_chk_w(DATA_W),
  localparam int BODY_W = DATA_W + CHK_W
) (
  input  logic [BODY_W:0]  code_i,
  output logic [CHK_W-1:0] syn_o,
  output logic             par_err_o
);
  // Including the stored check bit in each sum gives stored ^ recomputed.
  always_comb begin
    for (int j = 0; j < CHK_W; j++) begin
      syn_o[j] = 1'b0;
      for (int p = 1; p <= BODY_W; p++) begin
        if (((p >> j) & 1) == 1) syn_o[j] = syn_o[j] ^ code_i[p-1];
      end
    end
  end

  if (SECDED) begin : g_ovr
    assign par_err_o = ^code_i;
  end else begin : g_noovr
    assign par_err_o = 1'b0;
  end
endmodule

// File: rtl/ecc_hamming_fix.sv
module ecc_hamming_fix
  import ecc_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  localparam int CHK_W  = calc_chk_w(DATA_W),
  localparam int BODY_W = DATA_W + CHK_W
) (
  input  logic [BODY_W:0]   code_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              par_err_i,
  output logic [DATA_W-1:0] data_o,
  output rd_flags_t         flags_o
);
  localparam logic [CHK_W-1:0] MAX_POS = CHK_W'(BODY_W);

  logic nonzero, in_range, single, fatal;

  assign nonzero  = |syn_i;
  assign in_range = nonzero && (syn_i <= MAX_POS);

  if (SECDED) begin : g_secded
    assign single = par_err_i && (!nonzero || in_range);
    assign fatal  = nonzero && (!par_err_i || !in_range);
  end else begin : g_sec
    assign single = in_range;
    assign fatal  = nonzero && !in_range;
  end

  // Only data positions are repaired; a check-bit hit leaves data as is.
  for (genvar p = 1; p <= BODY_W; p++) begin : g_pos
    if ((p & (p - 1)) != 0) begin : g_dat
      assign data_o[p-1-$clog2(p+1)] =
        code_i[p-1] ^ (single && (syn_i == CHK_W'(p)));
    end
  end

  assign flags_o.corrected = single;
  assign flags_o.fatal     = fatal;
endmodule

// File: rtl/ecc_byte_codec.sv
module ecc_byte_codec
  import ecc_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit SECDED = 1'b1,
  localparam int CHK_W  = calc_chk_w(DATA_W),
  localparam int BODY_W = DATA_W + CHK_W,
  localparam int CODE_W = BODY_W + 1,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              parity_mode,
  input  logic              parity_odd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] wr_code,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_code,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_corrected,
  output logic              rd_uncorrectable
);
  logic rst_q;

  ecc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // Hamming paths
  logic [CODE_W-1:0] ham_code;
  logic [CHK_W-1:0]  syn;
  logic              par_err;
  logic [DATA_W-1:0] ham_data;
  rd_flags_t         ham_flags;

  ecc_hamming_enc #(.DATA_W(DATA_W), .SECDED(SECDED)) u_enc (
    .data_i(wr_data), .code_o(ham_code));

  ecc_hamming_syn #(.DATA_W(DATA_W), .SECDED(SECDED)) u_syn (
    .code_i(rd_code), .syn_o(syn), .par_err_o(par_err));

  ecc_hamming_fix #(.DATA_W(DATA_W), .SECDED(SECDED)) u_fix (
    .code_i(rd_code), .syn_i(syn), .par_err_i(par_err),
    .data_o(ham_data), .flags_o(ham_flags));

  // Per-byte parity paths
  logic [NBYTES-1:0] par_bits, par_bad;
  logic [CODE_W-1:0] par_code;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign par_bits[b] = (^wr_data[8*b +: 8]) ^ parity_odd;
    assign par_bad[b]  = (^rd_code[8*b +: 8]) ^ rd_code[DATA_W+b] ^ parity_odd;
  end

  assign par_code = {{(CODE_W-DATA_W-NBYTES){1'b0}}, par_bits, wr_data};

  // Next state
  logic [CODE_W-1:0] wr_code_d;
  logic [DATA_W-1:0] rd_data_d;
  logic              rd_corr_d, rd_unc_d;

  always_comb begin
    wr_code_d = wr_code;
    rd_data_d = rd_data;
    rd_corr_d = rd_corrected;
    rd_unc_d  = rd_uncorrectable;
    if (wr_en) begin
      wr_code_d = parity_mode ? par_code : ham_code;
    end
    if (rd_en) begin
      if (parity_mode) begin
        rd_data_d = rd_code[DATA_W-1:0];
        rd_corr_d = 1'b0;
        rd_unc_d  = |par_bad;
      end else begin
        rd_data_d = ham_data;
        rd_corr_d = ham_flags.corrected;
        rd_unc_d  = ham_flags.fatal;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      wr_code          <= '0;
      rd_data          <= '0;
      rd_corrected     <= 1'b0;
      rd_uncorrectable <= 1'b0;
    end else begin
      wr_code          <= wr_code_d;
      rd_data          <= rd_data_d;
      rd_corrected     <= rd_corr_d;
      rd_uncorrectable <= rd_unc_d;
    end
  end

  // Checks
  if (SECDED) begin : g_ovr_chk
    assert_even_overall_R1: assert property (@(posedge clk) disable iff (!rst_q)
      (wr_en && !parity_mode) |=> !(^wr_code));
  end

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_en |=> $stable(wr_code));

  assert_clean_flags_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && !parity_mode && (syn == '0) && !par_err)
      |=> (!rd_corrected && !rd_uncorrectable));

  assert_parity_no_fix_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && parity_mode) |=> !rd_corrected);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> ($stable(rd_data) && $stable(rd_corrected) && $stable(rd_uncorrectable)));

  assert_flags_excl_R12: assert property (@(posedge clk) disable iff (!rst_q)
    !(rd_corrected && rd_uncorrectable));
endmodule

// File: tb/ecc_byte_codec_test.sv
module ecc_byte_codec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        parity_mode, parity_odd, wr_en, rd_en;
  logic [7:0]  wr_data, rd_data;
  logic [12:0] wr_code, rd_code;
  logic        rd_corrected, rd_uncorrectable;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ecc_byte_codec uut (
    .clk(clk), .rst_n(rst_n), .parity_mode(parity_mode), .parity_odd(parity_odd),
    .wr_en(wr_en), .wr_data(wr_data), .wr_code(wr_code),
    .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_data),
    .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable));

  function automatic logic [12:0] model_enc(input logic [7:0] d);
    logic k1, k2, k4, k8;
    logic [11:0] w;
    k1 = d[0]^d[1]^d[3]^d[4]^d[6];
    k2 = d[0]^d[2]^d[3]^d[5]^d[6];
    k4 = d[1]^d[2]^d[3]^d[7];
    k8 = d[4]^d[5]^d[6]^d[7];
    w  = {d[7], d[6], d[5], d[4], k8, d[3], d[2], d[1], k4, d[0], k2, k1};
    return {^w, w};
  endfunction

  function automatic logic [7:0] raw_bits(input logic [12:0] c);
    return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr_cycle(input logic pm, input logic odd, input logic [7:0] d);
    parity_mode = pm; parity_odd = odd; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_cycle(input logic pm, input logic odd, input logic [12:0] c);
    parity_mode = pm; parity_odd = odd; rd_code = c; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] ed, input logic ec, input logic eu);
    chk(rd_data == ed, req, {8'h0, rd_data}, {8'h0, ed});
    chk({rd_corrected, rd_uncorrectable} == {ec, eu}, req,
        {14'h0, rd_corrected, rd_uncorrectable}, {14'h0, ec, eu});
    chk(!(rd_corrected && rd_uncorrectable), "R12", {15'h0, rd_corrected}, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [12:0] cw;
    logic [12:0] bad;
    rst_n = 1'b0; parity_mode = 1'b0; parity_odd = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00; rd_code = 13'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(wr_code == 13'h0, "R11 wr_code", {3'h0, wr_code}, 16'h0);
    chk(rd_data == 8'h0 && !rd_corrected && !rd_uncorrectable, "R11 read side",
        {6'h0, rd_corrected, rd_uncorrectable, rd_data}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 worked example
    wr_cycle(1'b0, 1'b0, 8'h39);
    chk(wr_code == 13'h134F, "R1 example", {3'h0, wr_code}, 16'h134F);
    // R2 hold with wr_en low
    wr_data = 8'hC3;
    @(negedge clk);
    chk(wr_code == 13'h134F, "R2 hold", {3'h0, wr_code}, 16'h134F);
    // R4 worked example: position 6 flipped
    rd_cycle(1'b0, 1'b0, 13'h136F);
    rd_expect("R4 example", 8'h39, 1'b1, 1'b0);
    // R10 hold with rd_en low
    rd_code = 13'h0AAA;
    @(negedge clk);
    rd_expect("R10 hold", 8'h39, 1'b1, 1'b0);

    for (int d = 0; d < 256; d++) begin
      wr_cycle(1'b0, 1'b0, 8'(d));
      cw = model_enc(8'(d));
      chk(wr_code == cw, "R1 encode", {3'h0, wr_code}, {3'h0, cw});
      rd_cycle(1'b0, 1'b0, cw);
      rd_expect("R3 clean", 8'(d), 1'b0, 1'b0);
      for (int p = 0; p < 13; p++) begin
        rd_cycle(1'b0, 1'b0, cw ^ (13'h1 << p));
        if (p == 0 || p == 1 || p == 3 || p == 7 || p == 12)
          rd_expect("R5 check-bit flip", 8'(d), 1'b1, 1'b0);
        else
          rd_expect("R4 data flip", 8'(d), 1'b1, 1'b0);
      end
      for (int p = 0; p < 12; p++) begin
        for (int q = p + 1; q < 13; q++) begin
          bad = cw ^ (13'h1 << p) ^ (13'h1 << q);
          rd_cycle(1'b0, 1'b0, bad);
          rd_expect("R6 double flip", raw_bits(bad), 1'b0, 1'b1);
        end
      end
      bad = cw ^ 13'h0089;
      rd_cycle(1'b0, 1'b0, bad);
      rd_expect("R7 syndrome 13", raw_bits(bad), 1'b0, 1'b1);
      bad = cw ^ 13'h008A;
      rd_cycle(1'b0, 1'b0, bad);
      rd_expect("R7 syndrome 14", raw_bits(bad), 1'b0, 1'b1);
      bad = cw ^ 13'h008C;
      rd_cycle(1'b0, 1'b0, bad);
      rd_expect("R7 syndrome 15", raw_bits(bad), 1'b0, 1'b1);
    end

    for (int odd = 0; odd < 2; odd++) begin
      for (int d = 0; d < 256; d++) begin
        wr_cycle(1'b1, 1'(odd), 8'(d));
        cw = {4'h0, (^8'(d)) ^ 1'(odd), 8'(d)};
        chk(wr_code == cw, "R8 parity encode", {3'h0, wr_code}, {3'h0, cw});
        rd_cycle(1'b1, 1'(odd), cw);
        rd_expect("R9 parity clean", 8'(d), 1'b0, 1'b0);
        for (int k = 0; k < 9; k++) begin
          bad = cw ^ (13'h1 << k);
          rd_cycle(1'b1, 1'(odd), bad);
          rd_expect("R9 parity error", bad[7:0], 1'b0, 1'b1);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule